// File: doc/BRIEF.md
# Shared Second-Level Translation Buffer

This block is a second-level translation cache that two first-level translators share. The instruction-fetch side and the data side each have their own small first-level buffer. When one of them misses, it sends the virtual address here. The block holds 128 translations in a two-way set-associative array of 64 sets. On a hit it returns the physical address together with memory attributes. Attribute combinations that the memory system does not implement are rewritten into ones it does implement. On a miss it sends a walk request to an external table walker and waits for that walker to return a refill entry. It writes the entry into the array and then repeats the lookup, which now hits and produces the response.

Four page sizes can be resident: 4 KB, 64 KB, 1 MB and 16 MB. Each size takes its set index from a different slice of virtual-address bits, so a lookup has to probe each size on its own, one probe per cycle, smallest size first. A four-bit size map records which sizes have been written since the last flush. Sizes that are not in the map are not probed. A single flush input clears every valid bit and the size map in one cycle.

All data-carrying interfaces use valid/ready. A requester holds its valid and address stable until it sees ready. A response holds its valid and its fields stable until the response ready is seen. A walk request holds the same way until the walk ready is seen. The fill ready is high only while the block is waiting for a refill. Only one lookup is in flight at a time: both request readies stay low from the moment a request is accepted until its response has been taken.

Top module: `tlbu_top`

## Requirements
- R1: When both requesters are valid in the same cycle, the data side is granted and instruction-side ready stays low. The instruction request is served later, once the block is idle again. `rsp_is_data` reads 1 for a data-side response and 0 for an instruction-side response.
- R2: On a hit, `rsp_pa` is made of two parts. Bits at and above the page offset come from the entry's physical page number. The offset bits come from the request VA. The offset width is 12, 16, 20 or 24 bits for size codes 0, 1, 2 and 3 respectively.
- R3: An entry hits only when two conditions hold. Its VA bits above the page offset must match the request. Its global flag must be set, or its stored ASID must equal the ASID that was captured when the request was accepted.
- R4: A lookup that misses raises `walk_valid` with the request's VA and ASID and holds them until `walk_ready` is seen. After that, `fill_ready` is high until a fill is accepted. The filled entry then serves the response.
- R5: From the clock edge that accepts a request until the edge that accepts its response, both request readies are low.
- R6: Let the accept edge be edge 0. A hit on the k-th size that is present in the size map is visible after edge k. A miss raises `walk_valid` after edge m, where m is the number of sizes present. With an empty map, m is 0.
- R7: Cache codes are 0 non-cacheable, 1 write-back write-allocate, 2 write-through and 3 write-back no-write-allocate. Code 2 is reported as 0, code 3 is reported as 1, and the other codes pass through unchanged. Share codes are 0 non-shared, 1 inner and 2 or 3 outer. Outer is reported as 1.
- R8: A one-cycle `flush_all` pulse invalidates every entry and empties the size map. A following lookup of any earlier page misses after edge 0.
- R9: Each set has one round-robin bit. The first fill of a set goes to way 0, the next to way 1, and so on alternately. A third distinct page in a set therefore evicts the first and keeps the second.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response valid and all response fields stay unchanged.
- R11: After reset, no response or walk is pending and both request readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | 8 | Current address-space ID, captured at request accept |
| flush_all | input | 1 | Invalidate all entries and clear the size map |
| d_req_valid | input | 1 | Data-side miss request valid |
| d_req_ready | output | 1 | Data-side request accepted |
| d_req_va | input | 32 | Data-side virtual address |
| i_req_valid | input | 1 | Instruction-side miss request valid |
| i_req_ready | output | 1 | Instruction-side request accepted |
| i_req_va | input | 32 | Instruction-side virtual address |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_is_data | output | 1 | 1 when the response belongs to the data side |
| rsp_pa | output | 32 | Physical address |
| rsp_cache | output | 2 | Folded cache policy code |
| rsp_share | output | 2 | Folded shareability code |
| walk_valid | output | 1 | Walk request valid |
| walk_ready | input | 1 | Walk request accepted |
| walk_va | output | 32 | VA to walk |
| walk_asid | output | 8 | ASID of the walk |
| fill_valid | input | 1 | Refill entry valid |
| fill_ready | output | 1 | Block waits for a refill |
| fill_ppn | input | 20 | Physical page number in 4 KB units |
| fill_size | input | 2 | Page size code 0..3 |
| fill_global | input | 1 | Entry matches any ASID |
| fill_cache | input | 2 | Raw cache policy code |
| fill_share | input | 2 | Raw shareability code |

## Verification
The main function is exercised with several directed patterns.
- Pages of all four sizes are filled into an emptied array, and addresses inside each page are then looked up. This separates the set-index and offset slices of each size, and the latency shows which sizes were actually probed.
- A non-global page is looked up again with a different ASID, and then a global page is looked up with a third ASID. This separates the two ways an entry can satisfy the ASID condition.
- Three pages that map to one set separate round-robin replacement from any other victim choice.
- Requests raised on both sides in the same cycle, and responses held back for several cycles, exercise arbitration and back-pressure.

After these, a seeded random mix of ports, ASIDs, sizes, attribute codes and occasional flushes runs over a small address pool. A reference model in the bench predicts, for every lookup, whether it hits or misses, how many probe cycles it takes, the physical address and the folded attributes.

// File: rtl/tlbu_pkg.sv
package tlbu_pkg;
  localparam int unsigned VA_W    = 32;
  localparam int unsigned OFS_W   = 12;
  localparam int unsigned VPN_W   = VA_W - OFS_W;
  localparam int unsigned ASID_W  = 8;
  localparam int unsigned SET_W   = 6;
  localparam int unsigned N_SETS  = 1 << SET_W;
  localparam int unsigned N_WAYS  = 2;
  localparam int unsigned N_SIZES = 4;

  typedef struct packed {
    logic [1:0]        size;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [1:0]        cache;
    logic [1:0]        share;
  } tlbu_entry_t;

  // each size step widens the page offset by four bits
  function automatic logic [SET_W-1:0] set_index(logic [VPN_W-1:0] vpn, logic [1:0] sz);
    return SET_W'(vpn >> {sz, 2'b00});
  endfunction

  function automatic logic vpn_match(logic [VPN_W-1:0] a, logic [VPN_W-1:0] b, logic [1:0] sz);
    return ((a ^ b) >> {sz, 2'b00}) == '0;
  endfunction

  // lowest resident size at or above 'from'; bit 2 set means none
  function automatic logic [2:0] pick_size(logic [N_SIZES-1:0] map, logic [1:0] from);
    logic [2:0] r;
    r = 3'b100;
    for (int i = N_SIZES - 1; i >= 0; i--) begin
      if (map[i] && (i >= int'(from))) r = {1'b0, 2'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/tlbu_arb.sv
module tlbu_arb import tlbu_pkg::*; (
  input  logic            idle,
  input  logic            d_valid,
  input  logic [VA_W-1:0] d_va,
  input  logic            i_valid,
  input  logic [VA_W-1:0] i_va,
  output logic            d_ready,
  output logic            i_ready,
  output logic            take,
  output logic            take_data,
  output logic [VA_W-1:0] take_va
);
  assign d_ready   = idle;
  assign i_ready   = idle && !d_valid;
  assign take_data = d_valid;
  assign take      = idle && (d_valid || i_valid);
  assign take_va   = d_valid ? d_va : i_va;
endmodule

// File: rtl/tlbu_fold.sv
module tlbu_fold (
  input  logic [1:0] cache_raw,
  input  logic [1:0] share_raw,
  output logic [1:0] cache_out,
  output logic [1:0] share_out
);
  always_comb begin
    unique case (cache_raw)
      2'd2:    cache_out = 2'd0;
      2'd3:    cache_out = 2'd1;
      default: cache_out = cache_raw;
    endcase
    share_out = share_raw[1] ? 2'd1 : share_raw;
  end
endmodule

// File: rtl/tlbu_store.sv
module tlbu_store import tlbu_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [1:0]         probe_size,
  input  logic [VPN_W-1:0]   probe_vpn,
  input  logic [ASID_W-1:0]  probe_asid,
  output logic               hit,
  output logic [VPN_W-1:0]   hit_ppn,
  output logic [1:0]         hit_cache,
  output logic [1:0]         hit_share,
  input  logic               wr_en,
  input  tlbu_entry_t        wr_entry,
  output logic [N_SIZES-1:0] size_map
);
  logic [N_SETS-1:0] valid_q [N_WAYS];
  tlbu_entry_t       ent_q   [N_WAYS][N_SETS];
  logic [N_SETS-1:0] rr_q;
  logic [N_SIZES-1:0] map_q;

  logic [SET_W-1:0] wr_set, p_set;
  logic             wr_way;
  logic [N_WAYS-1:0] way_hit;
  tlbu_entry_t       way_ent [N_WAYS];

  assign wr_set   = set_index(wr_entry.vpn, wr_entry.size);
  assign wr_way   = rr_q[wr_set];
  assign p_set    = set_index(probe_vpn, probe_size);
  assign size_map = map_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < N_WAYS; w++) valid_q[w] <= '0;
      rr_q  <= '0;
      map_q <= '0;
    end else if (flush) begin
      for (int w = 0; w < N_WAYS; w++) valid_q[w] <= '0;
      map_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_way][wr_set] <= 1'b1;
      rr_q[wr_set]            <= ~rr_q[wr_set];
      map_q[wr_entry.size]    <= 1'b1;
    end
  end

  for (genvar w = 0; w < N_WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (wr_en && !flush && (wr_way == 1'(w))) ent_q[w][wr_set] <= wr_entry;
    end
    assign way_ent[w] = ent_q[w][p_set];
    assign way_hit[w] = valid_q[w][p_set] && (way_ent[w].size == probe_size)
                     && vpn_match(way_ent[w].vpn, probe_vpn, probe_size)
                     && (way_ent[w].glob || (way_ent[w].asid == probe_asid));
  end

  always_comb begin
    hit       = |way_hit;
    hit_ppn   = way_ent[N_WAYS-1].ppn;
    hit_cache = way_ent[N_WAYS-1].cache;
    hit_share = way_ent[N_WAYS-1].share;
    for (int w = N_WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit_ppn   = way_ent[w].ppn;
        hit_cache = way_ent[w].cache;
        hit_share = way_ent[w].share;
      end
    end
  end
endmodule

// File: rtl/tlbu_top.sv
module tlbu_top import tlbu_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              flush_all,
  input  logic              d_req_valid,
  output logic              d_req_ready,
  input  logic [VA_W-1:0]   d_req_va,
  input  logic              i_req_valid,
  output logic              i_req_ready,
  input  logic [VA_W-1:0]   i_req_va,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_is_data,
  output logic [VA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_cache,
  output logic [1:0]        rsp_share,
  output logic              walk_valid,
  input  logic              walk_ready,
  output logic [VA_W-1:0]   walk_va,
  output logic [ASID_W-1:0] walk_asid,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_ppn,
  input  logic [1:0]        fill_size,
  input  logic              fill_global,
  input  logic [1:0]        fill_cache,
  input  logic [1:0]        fill_share
);
  typedef enum logic [2:0] {ST_IDLE, ST_PROBE, ST_WALK, ST_FILL, ST_RESP} st_e;

  st_e               st_q, st_d;
  logic [1:0]        cur_q, cur_d;
  logic [VA_W-1:0]   pva_q;
  logic [ASID_W-1:0] pasid_q;
  logic              pdata_q;
  logic [VA_W-1:0]   rpa_q;
  logic [1:0]        rcache_q, rshare_q;

  logic              take, take_data;
  logic [VA_W-1:0]   take_va;
  logic              hit;
  logic [VPN_W-1:0]  hit_ppn;
  logic [1:0]        hit_cache, hit_share, fold_cache, fold_share;
  logic [N_SIZES-1:0] size_map;
  logic [2:0]        first_sz, next_sz;
  logic              wr_en;
  tlbu_entry_t       wr_entry;
  logic [4:0]        ofs_bits;
  logic [VA_W-1:0]   ofs_mask, hit_pa;

  tlbu_arb u_arb (
    .idle(st_q == ST_IDLE), .d_valid(d_req_valid), .d_va(d_req_va),
    .i_valid(i_req_valid), .i_va(i_req_va), .d_ready(d_req_ready),
    .i_ready(i_req_ready), .take(take), .take_data(take_data), .take_va(take_va)
  );

  assign wr_en    = (st_q == ST_FILL) && fill_valid;
  assign wr_entry = '{size: fill_size, vpn: pva_q[VA_W-1:OFS_W], ppn: fill_ppn,
                      asid: pasid_q, glob: fill_global, cache: fill_cache, share: fill_share};

  tlbu_store u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_all), .probe_size(cur_q),
    .probe_vpn(pva_q[VA_W-1:OFS_W]), .probe_asid(pasid_q), .hit(hit),
    .hit_ppn(hit_ppn), .hit_cache(hit_cache), .hit_share(hit_share),
    .wr_en(wr_en), .wr_entry(wr_entry), .size_map(size_map)
  );

  tlbu_fold u_fold (
    .cache_raw(hit_cache), .share_raw(hit_share),
    .cache_out(fold_cache), .share_out(fold_share)
  );

  assign first_sz = pick_size(size_map, 2'd0);
  assign next_sz  = (cur_q == 2'd3) ? 3'b100 : pick_size(size_map, cur_q + 2'd1);
  assign ofs_bits = 5'd12 + {1'b0, cur_q, 2'b00};
  assign ofs_mask = {VA_W{1'b1}} << ofs_bits;
  assign hit_pa   = ({hit_ppn, {OFS_W{1'b0}}} & ofs_mask) | (pva_q & ~ofs_mask);

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    unique case (st_q)
      ST_IDLE: if (take) begin
        if (first_sz[2]) st_d = ST_WALK;
        else begin
          st_d  = ST_PROBE;
          cur_d = first_sz[1:0];
        end
      end
      ST_PROBE: begin
        if (hit) st_d = ST_RESP;
        else if (next_sz[2]) st_d = ST_WALK;
        else cur_d = next_sz[1:0];
      end
      ST_WALK: if (walk_ready) st_d = ST_FILL;
      ST_FILL: if (fill_valid) begin
        st_d  = ST_PROBE;
        cur_d = (first_sz[2] || (fill_size < first_sz[1:0])) ? fill_size : first_sz[1:0];
      end
      ST_RESP: if (rsp_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      pva_q    <= '0;
      pasid_q  <= '0;
      pdata_q  <= 1'b0;
      rpa_q    <= '0;
      rcache_q <= '0;
      rshare_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      if (take) begin
        pva_q   <= take_va;
        pasid_q <= cur_asid;
        pdata_q <= take_data;
      end
      if ((st_q == ST_PROBE) && hit) begin
        rpa_q    <= hit_pa;
        rcache_q <= fold_cache;
        rshare_q <= fold_share;
      end
    end
  end

  assign rsp_valid   = st_q == ST_RESP;
  assign rsp_is_data = pdata_q;
  assign rsp_pa      = rpa_q;
  assign rsp_cache   = rcache_q;
  assign rsp_share   = rshare_q;
  assign walk_valid  = st_q == ST_WALK;
  assign walk_va     = pva_q;
  assign walk_asid   = pasid_q;
  assign fill_ready  = st_q == ST_FILL;
endmodule

// File: rtl/tlbu_chk.sv
module tlbu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush_all,
  input logic        d_req_valid,
  input logic        d_req_ready,
  input logic        i_req_valid,
  input logic        i_req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_pa,
  input logic [1:0]  rsp_cache,
  input logic [1:0]  rsp_share,
  input logic        walk_valid,
  input logic        walk_ready,
  input logic [31:0] walk_va,
  input logic [3:0]  size_map
);
  logic accepted;
  assign accepted = (d_req_valid && d_req_ready) || (i_req_valid && i_req_ready);

  AST_DATA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    d_req_valid |-> !i_req_ready); // R1
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid || rsp_valid) |-> (!d_req_ready && !i_req_ready)); // R5
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_cache))); // R10
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && !walk_ready) |=> (walk_valid && $stable(walk_va))); // R4
  AST_FOLDED_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!rsp_cache[1] && !rsp_share[1])); // R7
  AST_FLUSH_CLEARS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (size_map == 4'b0000)); // R8
  AST_EMPTY_MAP_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && (size_map == 4'b0000)) |=> walk_valid); // R6
endmodule

bind tlbu_top tlbu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
  .d_req_valid(d_req_valid), .d_req_ready(d_req_ready),
  .i_req_valid(i_req_valid), .i_req_ready(i_req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
  .rsp_cache(rsp_cache), .rsp_share(rsp_share),
  .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_va(walk_va),
  .size_map(size_map)
);

// File: tb/tlbu_top_tb_top.sv
module tlbu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic        flush_all = 1'b0;
  logic        d_req_valid = 1'b0, i_req_valid = 1'b0;
  logic        d_req_ready, i_req_ready;
  logic [31:0] d_req_va = '0, i_req_va = '0;
  logic        rsp_valid, rsp_is_data;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_cache, rsp_share;
  logic        walk_valid;
  logic        walk_ready = 1'b0;
  logic [31:0] walk_va;
  logic [7:0]  walk_asid;
  logic        fill_valid = 1'b0, fill_ready;
  logic [19:0] fill_ppn = '0;
  logic [1:0]  fill_size = '0, fill_cache = '0, fill_share = '0;
  logic        fill_global = 1'b0;

  tlbu_top dut_i (.*);

  always #5 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errs++; checks++;
      $display("FAIL watchdog all-reqs act=%0d exp<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // reference model
  bit        m_v    [2][64];
  bit [1:0]  m_sz   [2][64];
  bit [19:0] m_vpn  [2][64];
  bit [19:0] m_ppn  [2][64];
  bit [7:0]  m_asid [2][64];
  bit        m_g    [2][64];
  bit [1:0]  m_c    [2][64];
  bit [1:0]  m_s    [2][64];
  bit        m_rr   [64];
  bit [3:0]  m_map = '0;

  function automatic int sidx(bit [19:0] vpn, int sz);
    return int'((vpn >> (4 * sz)) & 20'h3F);
  endfunction

  function automatic bit mdl_find(bit [31:0] va, bit [7:0] asid,
                                  output int way, output int set, output int probes);
    bit found = 0;
    probes = 0; way = 0; set = 0;
    for (int s = 0; s < 4; s++) begin
      if (m_map[s] && !found) begin
        int st;
        probes++;
        st = sidx(va[31:12], s);
        for (int w = 0; w < 2; w++) begin
          if (!found && m_v[w][st] && (int'(m_sz[w][st]) == s)
              && (((m_vpn[w][st] ^ va[31:12]) >> (4 * s)) == 0)
              && (m_g[w][st] || (m_asid[w][st] == asid))) begin
            found = 1; way = w; set = st;
          end
        end
      end
    end
    return found;
  endfunction

  function automatic bit [31:0] exp_pa(int w, int st, bit [31:0] va);
    bit [31:0] mask;
    mask = 32'hFFFF_FFFF << (12 + 4 * int'(m_sz[w][st]));
    return ({m_ppn[w][st], 12'h000} & mask) | (va & ~mask);
  endfunction

  function automatic bit [1:0] fold_c(bit [1:0] c);
    return (c == 2) ? 2'd0 : (c == 3) ? 2'd1 : c;
  endfunction

  function automatic bit [1:0] fold_s(bit [1:0] s);
    return s[1] ? 2'd1 : s;
  endfunction

  function automatic void mdl_write(bit [31:0] va, bit [7:0] asid, bit [1:0] sz,
                                    bit [19:0] ppn, bit g, bit [1:0] c, bit [1:0] s);
    int st, w;
    st = sidx(va[31:12], sz);
    w  = int'(m_rr[st]);
    m_v[w][st] = 1; m_sz[w][st] = sz; m_vpn[w][st] = va[31:12]; m_ppn[w][st] = ppn;
    m_asid[w][st] = asid; m_g[w][st] = g; m_c[w][st] = c; m_s[w][st] = s;
    m_rr[st] = ~m_rr[st];
    m_map[sz] = 1;
  endfunction

  task automatic do_flush();
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    for (int w = 0; w < 2; w++) for (int s = 0; s < 64; s++) m_v[w][s] = 0;
    m_map = '0;
  endtask

  // one complete lookup; called and returns at a falling edge
  task automatic lookup(input bit is_data, input bit [31:0] va, input bit [7:0] asid,
                        input bit [1:0] fsz, input bit [19:0] fppn, input bit fg,
                        input bit [1:0] fc, input bit [1:0] fs, input int hold,
                        output bit was_hit, output bit [31:0] pa_o);
    int w, st, probes, n, t;
    bit found;
    bit [31:0] pa_e, pa_keep;
    cur_asid = asid;
    if (is_data) begin d_req_valid = 1'b1; d_req_va = va; end
    else begin i_req_valid = 1'b1; i_req_va = va; end
    #1;
    t = 0;
    while (!(is_data ? d_req_ready : i_req_ready) && t < 100) begin
      @(negedge clk); #1; t++;
    end
    @(negedge clk);
    d_req_valid = 1'b0; i_req_valid = 1'b0;
    found = mdl_find(va, asid, w, st, probes);
    was_hit = found;
    n = 0;
    while (!rsp_valid && !walk_valid && n < 20) begin
      @(negedge clk); n++;
    end
    chk("R6", "probe cycles", n, probes);
    if (walk_valid) begin
      chk("R4", "miss expected", 32'(found), 0);
      chk("R4", "walk va", walk_va, va);
      chk("R4", "walk asid", 32'(walk_asid), 32'(asid));
      chk("R5", "d ready busy", 32'(d_req_ready), 0);
      walk_ready = 1'b1;
      @(negedge clk);
      walk_ready = 1'b0;
      chk("R4", "fill ready", 32'(fill_ready), 1);
      fill_valid = 1'b1; fill_ppn = fppn; fill_size = fsz;
      fill_global = fg; fill_cache = fc; fill_share = fs;
      @(negedge clk);
      fill_valid = 1'b0;
      mdl_write(va, asid, fsz, fppn, fg, fc, fs);
      found = mdl_find(va, asid, w, st, probes);
      t = 0;
      while (!rsp_valid && t < 20) begin
        @(negedge clk); t++;
      end
    end else begin
      chk("R4", "hit expected", 32'(found), 1);
    end
    chk("R4", "response present", 32'(rsp_valid), 1);
    pa_e = exp_pa(w, st, va);
    chk("R2", "pa", rsp_pa, pa_e);
    chk("R1", "rsp side", 32'(rsp_is_data), 32'(is_data));
    chk("R7", "cache fold", 32'(rsp_cache), 32'(fold_c(m_c[w][st])));
    chk("R7", "share fold", 32'(rsp_share), 32'(fold_s(m_s[w][st])));
    chk("R5", "i ready busy", 32'(i_req_ready), 0);
    pa_o = rsp_pa;
    pa_keep = rsp_pa;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R10", "valid held", 32'(rsp_valid), 1);
      chk("R10", "pa held", rsp_pa, pa_keep);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    bit h;
    bit [31:0] pa;
    bit [31:0] pool [8];
    int tmp;
    tmp = $urandom(32'd4242);
    for (int i = 0; i < 8; i++) pool[i] = $urandom() & 32'hFFFF_F000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "d ready", 32'(d_req_ready), 1);
    chk("R11", "i ready", 32'(i_req_ready), 1);
    chk("R11", "rsp valid", 32'(rsp_valid), 0);
    chk("R11", "walk valid", 32'(walk_valid), 0);

    // write-through / outer on a 4 KB page, then hit it
    lookup(1, 32'h0000_3ABC, 8'd1, 2'd0, 20'h12345, 0, 2'd2, 2'd2, 0, h, pa);
    chk("R7", "wt to nc, outer to inner", {pa[31:12], 8'h0, 2'(0), 2'(0)},
        {20'h12345, 8'h0, 2'(0), 2'(0)});
    lookup(1, 32'h0000_3004, 8'd1, 2'd0, 20'h0, 0, 2'd0, 2'd0, 3, h, pa);
    chk("R6", "second lookup hits", 32'(h), 1);

    // round robin within set 3
    lookup(0, 32'h0004_3000, 8'd1, 2'd0, 20'h22222, 0, 2'd3, 2'd1, 0, h, pa);
    lookup(0, 32'h0008_3000, 8'd1, 2'd0, 20'h33333, 0, 2'd1, 2'd0, 0, h, pa);
    lookup(1, 32'h0004_3010, 8'd1, 2'd0, 20'h0, 0, 2'd0, 2'd0, 0, h, pa);
    chk("R9", "second page kept", 32'(h), 1);
    lookup(1, 32'h0000_3010, 8'd1, 2'd0, 20'h44444, 0, 2'd0, 2'd0, 0, h, pa);
    chk("R9", "first page evicted", 32'(h), 0);

    // ASID and global
    do_flush();
    lookup(1, 32'h1000_5000, 8'd5, 2'd0, 20'hAAAAA, 0, 2'd1, 2'd0, 0, h, pa);
    lookup(1, 32'h1000_5008, 8'd6, 2'd0, 20'hBBBBB, 1, 2'd1, 2'd0, 0, h, pa);
    chk("R3", "other asid misses", 32'(h), 0);
    lookup(1, 32'h1000_500C, 8'd7, 2'd0, 20'h0, 0, 2'd0, 2'd0, 0, h, pa);
    chk("R3", "global hits any asid", 32'(h), 1);

    // all four sizes
    do_flush();
    lookup(1, 32'h2001_2345, 8'd1, 2'd1, 20'h11110, 0, 2'd1, 2'd1, 0, h, pa);
    lookup(1, 32'h3045_6789, 8'd1, 2'd2, 20'h22200, 0, 2'd1, 2'd1, 0, h, pa);
    lookup(1, 32'h4ABC_DEF0, 8'd1, 2'd3, 20'hABCDE, 1, 2'd3, 2'd3, 0, h, pa);
    chk("R2", "16M pa", pa, 32'hABBC_DEF0);
    lookup(1, 32'h5000_1111, 8'd1, 2'd0, 20'h55555, 1, 2'd0, 2'd0, 0, h, pa);
    lookup(0, 32'h4A00_0004, 8'd1, 2'd0, 20'h0, 0, 2'd0, 2'd0, 0, h, pa);
    chk("R2", "16M second pa", pa, 32'hAB00_0004);
    lookup(0, 32'h2001_9999, 8'd1, 2'd0, 20'h0, 0, 2'd0, 2'd0, 0, h, pa);
    chk("R2", "64K pa", pa, 32'h1111_9999);

    // simultaneous requests
    cur_asid = 8'd1;
    d_req_valid = 1'b1; d_req_va = 32'h5000_1ABC;
    i_req_valid = 1'b1; i_req_va = 32'h5000_1DEF;
    #1;
    chk("R1", "data ready", 32'(d_req_ready), 1);
    chk("R1", "inst held off", 32'(i_req_ready), 0);
    @(negedge clk);
    d_req_valid = 1'b0;
    #1;
    chk("R5", "inst not taken while busy", 32'(i_req_ready), 0);
    for (int t = 0; t < 20 && !rsp_valid; t++) @(negedge clk);
    chk("R1", "data served first", 32'(rsp_is_data), 1);
    chk("R2", "data pa", rsp_pa, 32'h5555_5ABC);
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
    #1;
    for (int t = 0; t < 20 && !i_req_ready; t++) begin @(negedge clk); #1; end
    @(negedge clk);
    i_req_valid = 1'b0;
    for (int t = 0; t < 20 && !rsp_valid; t++) @(negedge clk);
    chk("R1", "inst served later", 32'(rsp_is_data), 0);
    chk("R2", "inst pa", rsp_pa, 32'h5555_5DEF);
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;

    // flush then previous page misses immediately
    do_flush();
    lookup(1, 32'h5000_1111, 8'd1, 2'd0, 20'h66666, 0, 2'd0, 2'd0, 0, h, pa);
    chk("R8", "flushed page misses", 32'(h), 0);

    // random mix
    for (int i = 0; i < 250; i++) begin
      bit [31:0] va;
      va = pool[$urandom_range(0, 7)] | ($urandom() & 32'h0000_0FFF);
      if ($urandom_range(0, 39) == 0) do_flush();
      lookup(1'($urandom_range(0, 1)), va, 8'($urandom_range(1, 3)),
             2'($urandom_range(0, 3)), 20'($urandom()), 1'($urandom_range(0, 1)),
             2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
             $urandom_range(0, 2), h, pa);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule